// File: doc/BRIEF.md
# Two-Wire Bus Line Override and Stuck-Bus Recovery Sequencer

This block sits beside a two-wire open-drain serial bus controller. It gives the host direct control over the clock and data lines and shows their live levels. A host register holds one override bit per line. Setting a bit pulls its line low through the open-drain enable. Clearing the bit lets the line float up to the pull-up. Two read-only bits in the same register report the synchronized level of each line.

A target that is reset in the middle of a read can hold the data line low indefinitely. To free it, the host pulses a start input, and the block runs a fixed recovery on its own:
- nine clock pulses, each one half-period released followed by one half-period low, with the data line released;
- one half-period with both lines low;
- one half-period with the clock released and the data line still low;
- release of the data line, which forms a stop condition.

Every step lasts a programmable number of clock cycles. A one-cycle done pulse marks the end of the sequence.

Top module: `line_clear_top`

## Requirements
- R1: After reset, both open-drain enables are 0, busy and done are 0, and the register reads `0x0C00` when both lines are high. Bits 11 and 10 are level bits and read 1.
- R2: While idle, a register write loads bit 9 (clock override) and bit 8 (data override). A 1 drives `sclOe`/`sdaOe` high, pulling the line low, from the cycle after the write edge. Every other written bit is ignored, and every bit other than 8 to 11 reads 0.
- R3: Bit 11 reads the clock line level and bit 10 reads the data line level. Each passes through two synchronizer flops, so a change shows on the third sample after it.
- R4: A start pulse while idle raises busy at the next edge. The block then drives 18 steps that alternate clock released and clock low, starting with released: nine low pulses. The data line is released throughout these steps.
- R5: After the pulses, one step holds the data line low while the clock stays low.
- R6: Next, one step releases the clock while the data line stays low.
- R7: Then both lines return to the host overrides, which are 0, forming a stop condition. Busy falls at that edge, and done is high for exactly that one cycle.
- R8: Every step lasts `HALF_CYCLES` clock cycles, so busy lasts 20 × `HALF_CYCLES` cycles.
- R9: Register writes while busy are ignored. The override bits keep their value and the lines follow the sequencer.
- R10: Accepting a start clears both host override bits. A start while busy is ignored.
- R11: When a start and a write arrive in the same idle cycle, the start wins and both override bits end up 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Register write strobe |
| regWrData | input | 16 | Register write data (bits 9:8 used) |
| regRdData | output | 16 | Register read data: overrides 9:8, line levels 11:10 |
| startRecover | input | 1 | Start the stuck-bus recovery |
| recoverBusy | output | 1 | Recovery in progress |
| recoverDone | output | 1 | One-cycle pulse at the end of recovery |
| sclIn | input | 1 | Clock line level from the pad |
| sdaIn | input | 1 | Data line level from the pad |
| sclOe | output | 1 | Pull the clock line low when 1 |
| sdaOe | output | 1 | Pull the data line low when 1 |

## Verification
The hardest behaviour to reach from the ports is a recovery started while a target model holds the data line low and the host is issuing writes and repeated starts on every cycle of the run. Only that combination shows that the sequencer owns the lines, ignores every competing request and frees the bus. The bench models the open-drain wires with a target that releases data after a chosen number of observed clock pulses. It fires random writes and starts in every busy cycle and compares each cycle against a step table computed from the half-period. Random idle writes with random target hold exercise the override bits, the reserved bits and the synchronized level bits.

// File: rtl/line_clear_pkg.sv
package line_clear_pkg;

  localparam int SDA_OVR_BIT = 8;
  localparam int SCL_OVR_BIT = 9;
  localparam int SDA_LVL_BIT = 10;
  localparam int SCL_LVL_BIT = 11;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PULSE = 2'd1,
    ST_HOLD  = 2'd2,
    ST_FREE  = 2'd3
  } seqState_t;

  typedef struct packed {
    logic timerLoad;
    logic stepInc;
    logic stepClr;
    logic hostClr;
    logic seqActive;
    logic seqSclLow;
    logic seqSdaLow;
  } seqStrobe_t;

endpackage

// File: rtl/line_clear_ctrl.sv
module line_clear_ctrl
  import line_clear_pkg::*;
#(
  parameter int PULSE_COUNT = 9,
  localparam int PULSE_STEPS = 2 * PULSE_COUNT,
  localparam int STEP_W = $clog2(PULSE_STEPS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startRecover,
  input  logic              timerDone,
  input  logic [STEP_W-1:0] stepCnt,
  output seqStrobe_t        strobe,
  output logic              recoverBusy,
  output logic              recoverDone
);

  seqState_t state, stateNext;
  logic doneNext;
  logic lastPulse;

  assign lastPulse = (stepCnt == STEP_W'(PULSE_STEPS - 1));

  always_comb begin
    stateNext = state;
    doneNext  = 1'b0;
    strobe    = '0;
    strobe.seqActive = (state != ST_IDLE);
    unique case (state)
      ST_IDLE: begin
        if (startRecover) begin
          stateNext        = ST_PULSE;
          strobe.timerLoad = 1'b1;
          strobe.stepClr   = 1'b1;
          strobe.hostClr   = 1'b1;
        end
      end
      ST_PULSE: begin
        strobe.seqSclLow = stepCnt[0];
        if (timerDone) begin
          strobe.timerLoad = 1'b1;
          if (lastPulse) stateNext = ST_HOLD;
          else           strobe.stepInc = 1'b1;
        end
      end
      ST_HOLD: begin
        strobe.seqSclLow = 1'b1;
        strobe.seqSdaLow = 1'b1;
        if (timerDone) begin
          strobe.timerLoad = 1'b1;
          stateNext        = ST_FREE;
        end
      end
      ST_FREE: begin
        strobe.seqSdaLow = 1'b1;
        if (timerDone) begin
          stateNext = ST_IDLE;
          doneNext  = 1'b1;
        end
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_IDLE;
      recoverDone <= 1'b0;
    end else begin
      state       <= stateNext;
      recoverDone <= doneNext;
    end
  end

  assign recoverBusy = (state != ST_IDLE);

endmodule

// File: rtl/line_clear_dp.sv
module line_clear_dp
  import line_clear_pkg::*;
#(
  parameter int HALF_CYCLES = 625,
  parameter int PULSE_COUNT = 9,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W = 16,
  localparam int TIMER_W = $clog2(HALF_CYCLES + 1),
  localparam int STEP_W = $clog2(2 * PULSE_COUNT)
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic              regWrEn,
  input  logic [REG_W-1:0]  regWrData,
  input  logic              sclIn,
  input  logic              sdaIn,
  output logic [REG_W-1:0]  regRdData,
  output logic              sclOe,
  output logic              sdaOe,
  output logic              timerDone,
  output logic [STEP_W-1:0] stepCnt
);

  logic hostSclOvr, hostSdaOvr;
  logic [TIMER_W-1:0] timer;
  logic sclLevel, sdaLevel;
  logic unusedWrBits;

  assign unusedWrBits = ^{regWrData[REG_W-1:SCL_OVR_BIT+1], regWrData[SDA_OVR_BIT-1:0]};

  // Host override bits; the sequencer owns them while active.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostSclOvr <= 1'b0;
      hostSdaOvr <= 1'b0;
    end else if (strobe.hostClr) begin
      hostSclOvr <= 1'b0;
      hostSdaOvr <= 1'b0;
    end else if (regWrEn && !strobe.seqActive) begin
      hostSclOvr <= regWrData[SCL_OVR_BIT];
      hostSdaOvr <= regWrData[SDA_OVR_BIT];
    end
  end

  // One down-counter times every step of the sequence.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                timer <= '0;
    else if (strobe.timerLoad) timer <= TIMER_W'(HALF_CYCLES - 1);
    else if (timer != '0)      timer <= timer - 1'b1;
  end
  assign timerDone = (timer == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               stepCnt <= '0;
    else if (strobe.stepClr) stepCnt <= '0;
    else if (strobe.stepInc) stepCnt <= stepCnt + 1'b1;
  end

  // Level synchronizers, reset to the released (high) level.
  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclLevel <= 1'b1;
          sdaLevel <= 1'b1;
        end else begin
          sclLevel <= sclIn;
          sdaLevel <= sdaIn;
        end
      end
    end else begin : g_syncN
      logic [SYNC_STAGES-1:0] sclChain, sdaChain;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclChain <= '1;
          sdaChain <= '1;
        end else begin
          sclChain <= {sclChain[SYNC_STAGES-2:0], sclIn};
          sdaChain <= {sdaChain[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclLevel = sclChain[SYNC_STAGES-1];
      assign sdaLevel = sdaChain[SYNC_STAGES-1];
    end
  endgenerate

  always_comb begin
    regRdData              = '0;
    regRdData[SDA_OVR_BIT] = hostSdaOvr;
    regRdData[SCL_OVR_BIT] = hostSclOvr;
    regRdData[SDA_LVL_BIT] = sdaLevel;
    regRdData[SCL_LVL_BIT] = sclLevel;
  end

  assign sclOe = strobe.seqActive ? strobe.seqSclLow : hostSclOvr;
  assign sdaOe = strobe.seqActive ? strobe.seqSdaLow : hostSdaOvr;

endmodule

// File: rtl/line_clear_top.sv
module line_clear_top
  import line_clear_pkg::*;
#(
  parameter int HALF_CYCLES = 625,
  parameter int PULSE_COUNT = 9,
  parameter int SYNC_STAGES = 2,
  parameter int REG_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [REG_W-1:0] regWrData,
  output logic [REG_W-1:0] regRdData,
  input  logic             startRecover,
  output logic             recoverBusy,
  output logic             recoverDone,
  input  logic             sclIn,
  input  logic             sdaIn,
  output logic             sclOe,
  output logic             sdaOe
);

  localparam int STEP_W = $clog2(2 * PULSE_COUNT);

  seqStrobe_t strobe;
  logic timerDone;
  logic [STEP_W-1:0] stepCnt;

  line_clear_ctrl #(.PULSE_COUNT(PULSE_COUNT)) ctrl_i (
    .clk(clk), .rstN(rstN), .startRecover(startRecover),
    .timerDone(timerDone), .stepCnt(stepCnt), .strobe(strobe),
    .recoverBusy(recoverBusy), .recoverDone(recoverDone)
  );

  line_clear_dp #(
    .HALF_CYCLES(HALF_CYCLES), .PULSE_COUNT(PULSE_COUNT),
    .SYNC_STAGES(SYNC_STAGES), .REG_W(REG_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWrEn(regWrEn),
    .regWrData(regWrData), .sclIn(sclIn), .sdaIn(sdaIn),
    .regRdData(regRdData), .sclOe(sclOe), .sdaOe(sdaOe),
    .timerDone(timerDone), .stepCnt(stepCnt)
  );

endmodule

// File: rtl/line_clear_chk.sv
module line_clear_chk #(
  parameter int HALF_CYCLES = 625,
  parameter int REG_W = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic [REG_W-1:0] regRdData,
  input logic             recoverBusy,
  input logic             recoverDone,
  input logic             sclOe,
  input logic             sdaOe
);

  logic prevScl;
  int unsigned runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b0;
      runLen  <= 0;
    end else begin
      prevScl <= sclOe;
      if (!recoverBusy || sclOe != prevScl) runLen <= 0;
      else runLen <= runLen + 1;
    end
  end

  p_done_pulse_r7: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |=> !recoverDone);

  p_done_at_end_r7: assert property (@(posedge clk) disable iff (!rstN)
    recoverDone |-> (!recoverBusy && $past(recoverBusy)));

  p_idle_follow_r2: assert property (@(posedge clk) disable iff (!rstN)
    !recoverBusy |-> (sclOe == regRdData[9] && sdaOe == regRdData[8]));

  p_data_low_clk_low_r5: assert property (@(posedge clk) disable iff (!rstN)
    (recoverBusy && $rose(sdaOe)) |-> sclOe);

  p_stop_order_r6: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sdaOe) && $past(recoverBusy)) |-> !sclOe);

  p_wr_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (recoverBusy && $past(recoverBusy)) |-> $stable(regRdData[9:8]));

  p_step_len_r8: assert property (@(posedge clk) disable iff (!rstN)
    runLen < 2 * HALF_CYCLES);

endmodule

bind line_clear_top line_clear_chk #(.HALF_CYCLES(HALF_CYCLES), .REG_W(REG_W)) chk_i (
  .clk(clk), .rstN(rstN), .regRdData(regRdData), .recoverBusy(recoverBusy),
  .recoverDone(recoverDone), .sclOe(sclOe), .sdaOe(sdaOe)
);

// File: tb/line_clear_top_tb_top.sv
`timescale 1ns/1ps
module line_clear_top_tb_top;

  localparam int H = 7;
  localparam int TOTAL = 20 * H;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic startRecover = 1'b0;
  logic recoverBusy, recoverDone, sclOe, sdaOe;
  logic tgtSdaLow = 1'b0;
  wire sclLine = !sclOe;
  wire sdaLine = !(sdaOe || tgtSdaLow);

  int checks = 0;
  int errs = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  line_clear_top #(.HALF_CYCLES(H)) dut_i (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdData(regRdData), .startRecover(startRecover),
    .recoverBusy(recoverBusy), .recoverDone(recoverDone),
    .sclIn(sclLine), .sdaIn(sdaLine), .sclOe(sclOe), .sdaOe(sdaOe)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wrapUp();
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  // {busy, done, sclOe, sdaOe} for sample c after the start edge
  function automatic logic [3:0] expSeq(input int c);
    int step = c / H;
    if (step < 18)       return {1'b1, 1'b0, 1'(step % 2), 1'b0};
    else if (step == 18) return 4'b1011;
    else if (step == 19) return 4'b1001;
    else                 return 4'b0100;
  endfunction

  function automatic logic [15:0] expReg(input logic sclOv, input logic sdaOv,
                                         input logic sclLv, input logic sdaLv);
    return {4'b0, sclLv, sdaLv, sclOv, sdaOv, 8'b0};
  endfunction

  task automatic hostWrite(input logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic runRecovery(input bit withWrite, input logic [15:0] wdata,
                             input int releaseAfter);
    int pulses = 0;
    logic prevScl = 1'b0;
    logic [3:0] e;
    string tag;
    @(negedge clk);
    startRecover = 1'b1;
    regWrEn = withWrite;
    regWrData = wdata;
    @(negedge clk);
    for (int c = 0; c <= TOTAL; c++) begin
      if (c > 0) @(negedge clk);
      e = expSeq(c);
      if (c / H < 18)       tag = "R4 R8 pulse step";
      else if (c / H == 18) tag = "R5 R8 data hold";
      else if (c / H == 19) tag = "R6 R8 clock free";
      else                  tag = "R7 stop/done";
      chk(tag, {recoverBusy, recoverDone, sclOe, sdaOe}, e);
      chk("R9 R10 R11 overrides cleared and held", regRdData[9:8], 2'b00);
      if (prevScl == 1'b0 && sclOe == 1'b1 && c < 18 * H) pulses++;
      prevScl = sclOe;
      if (releaseAfter > 0 && pulses == releaseAfter) tgtSdaLow = 1'b0;
      if (c < TOTAL) begin
        startRecover = 1'($urandom % 2);
        regWrEn = 1'($urandom % 2);
        regWrData = 16'($urandom);
      end else begin
        startRecover = 1'b0;
        regWrEn = 1'b0;
      end
    end
    chk("R4 nine clock pulses", pulses, 9);
    @(negedge clk);
    chk("R7 done one cycle", {recoverBusy, recoverDone, sclOe, sdaOe}, 4'b0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errs++;
    $display("FAIL watchdog expired");
    wrapUp();
  end

  initial begin
    logic [15:0] d;
    logic t;
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset outputs", {recoverBusy, recoverDone, sclOe, sdaOe}, 4'b0000);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset register", regRdData, 16'h0C00);

    // R2: directed override of each line; reserved bits ignored
    hostWrite(16'hF2FF);
    chk("R2 clock override drives", {sclOe, sdaOe}, 2'b10);
    repeat (2) @(negedge clk);
    chk("R2 R3 readback clock low", regRdData, expReg(1, 0, 0, 1));
    hostWrite(16'h0100);
    chk("R2 data override drives", {sclOe, sdaOe}, 2'b01);

    // R3: synchronizer latency
    hostWrite(16'h0000);
    repeat (2) @(negedge clk);
    @(negedge clk);
    tgtSdaLow = 1'b1;
    @(negedge clk);
    chk("R3 level not yet seen", regRdData[10], 1'b1);
    @(negedge clk);
    chk("R3 level after two stages", regRdData[10], 1'b0);

    // R2 R3 random idle writes with random target hold
    for (int i = 0; i < 30; i++) begin
      d = 16'($urandom);
      t = 1'($urandom % 2);
      tgtSdaLow = t;
      hostWrite(d);
      chk("R2 outputs follow write", {sclOe, sdaOe}, d[9:8]);
      repeat (2) @(negedge clk);
      chk("R2 R3 register readback", regRdData, expReg(d[9], d[8], !d[9], !(d[8] || t)));
    end

    // R10 R11: overrides set, start with a simultaneous write
    tgtSdaLow = 1'b0;
    hostWrite(16'h0300);
    runRecovery(1'b1, 16'h0300, 0);

    // Stuck target released after three pulses, writes hammered during busy
    tgtSdaLow = 1'b1;
    runRecovery(1'b0, 16'h0000, 3);
    repeat (3) @(negedge clk);
    chk("R3 data line freed after recovery", regRdData[11:10], 2'b11);

    // Plain recovery after override set again (R10 clears)
    hostWrite(16'h0200);
    runRecovery(1'b0, 16'h0000, 0);
    hostWrite(16'h0100);
    chk("R2 writes accepted again after done", {sclOe, sdaOe}, 2'b01);

    wrapUp();
  end

endmodule